// File: doc/BRIEF.md
# Suspend-Time Wake Filter with ARP Target Check

The block sits on the receive byte stream of an Ethernet port while the host is powered down. It keeps the first frame that passes its filter in a small on-chip byte store, so no main-memory traffic is needed. It then raises a single wake pulse. Once a frame is held, later frames are ignored until software has read the store and released it.

Three filter paths are available. The first is a masked compare of the destination address against a programmed station address. The second applies to broadcast frames whose two-byte type field equals a programmable value. Software normally sets that value to 0x0806, the ARP type. These frames wake the host only when the low byte of the requested target IP address equals the station's own low byte. Because most ARP broadcasts on a busy segment ask for other hosts, this rejects about 255 of every 256 of them. The third path covers all other broadcast frames, which are accepted or rejected by one enable input.

Top module: `wop_arp_filter`

## Requirements
- R1: After a synchronous reset, `wake` is 0, `buf_valid` is 0 and `held_len` is 0.
- R2: The block stores an accepted frame starting at store address 0 (the first destination byte) and reads it back combinationally through `rd_addr`/`rd_data`. Bytes beyond `BUF_BYTES` are not stored. `held_len` gives the full byte count of the frame.
- R3: For a frame whose destination (bytes 0..5, byte 0 being bits 47:40) is not all ones, a wake occurs only when `(dst ^ cfg_addr) & cfg_mask` is zero. A mask bit of 1 means the address bit is compared.
- R4: For a destination of all ones where bytes 12 (high) and 13 (low) equal `cfg_etype`, a wake occurs only when byte 41 equals `cfg_ip_lo`.
- R5: For a destination of all ones where the type differs from `cfg_etype`, a wake occurs exactly when `cfg_bcast_en` is 1.
- R6: A frame that ends before the bytes its path compares arrive does not wake the host and leaves `buf_valid` at 0. This applies below 6 bytes for any frame, below 14 bytes for a broadcast, and below 42 bytes for the ARP path.
- R7: While `buf_valid` is 1, new frames cause no wake and leave the stored bytes and `held_len` unchanged.
- R8: A one-cycle `buf_clear` drives `buf_valid` to 0 on the next cycle, and the next frame is then evaluated normally.
- R9: `wake` is a one-cycle pulse in the cycle after the beat that carries `rx_eof`. `buf_valid` rises in that same cycle.
- R10: A rejected frame frees the store: `buf_valid` stays 0 and the following frame is captured and judged.
- R11: A beat with `rx_sof` starts a new frame even if the previous frame had no end marker. The header compare uses only the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Received byte |
| cfg_addr | input | 48 | Station address |
| cfg_mask | input | 48 | Address compare mask, 1 = compare |
| cfg_etype | input | 16 | Broadcast type compare value (0x0806 for ARP) |
| cfg_ip_lo | input | 8 | Low byte of station IP address |
| cfg_bcast_en | input | 1 | Accept broadcasts of other types |
| buf_clear | input | 1 | Release the held frame |
| rd_addr | input | AW | Store read address |
| rd_data | output | 8 | Store read data |
| buf_valid | output | 1 | A frame is held |
| held_len | output | LEN_W | Byte count of the held frame |
| wake | output | 1 | Wake pulse |

## Verification
A vector table sends frames that differ in one field at a time. These include an exact unicast hit, a hit on a masked address byte, and a miss on an unmasked bit. They also include ARP broadcasts with a matching and a mismatching target byte, a non-ARP broadcast with the enable off, and frames whose end falls just before or exactly at the last compared byte. Together these separate the three filter paths and their length limits. Directed cases then cover the broadcast enable, the drop of frames while a frame is held, the release by clear, the restart on a start marker without an end, and readback of the stored bytes, including a frame longer than the store.

// File: rtl/wop_pkg.sv
package wop_pkg;

    localparam int ADDR_W      = 48;
    localparam int ETYPE_W     = 16;
    localparam int DST_BYTES   = 6;
    localparam int ETYPE_HI_AT = 12;
    localparam int ETYPE_LO_AT = 13;
    localparam int TIP_LO_AT   = 41;
    localparam int MIN_UNI     = DST_BYTES;
    localparam int MIN_TYPED   = ETYPE_LO_AT + 1;
    localparam int MIN_ARP     = TIP_LO_AT + 1;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_CAPT = 2'd1,
        RX_DROP = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eof;
        logic [7:0] data;
    } beat_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  dst;
        logic [ETYPE_W-1:0] etype;
        logic [7:0]         tip_lo;
    } hdr_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [ADDR_W-1:0]  mask;
        logic [ETYPE_W-1:0] etype;
        logic [7:0]         ip_lo;
        logic               bcast_en;
    } filt_cfg_t;

    function automatic logic is_bcast(input logic [ADDR_W-1:0] d);
        return &d;
    endfunction

endpackage

// File: rtl/wop_rx_track.sv
module wop_rx_track
    import wop_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  beat_t            beat,
    input  logic             hold,
    output logic             capt,
    output logic             capt_end,
    output logic             start,
    output logic [LEN_W-1:0] idx,
    output logic [LEN_W-1:0] len
);
    rx_state_e        state_q;
    logic [LEN_W-1:0] idx_q;

    always_comb begin
        start    = beat.valid && beat.sof;
        idx      = start ? '0 : idx_q;
        capt     = beat.valid && (start ? !hold : (state_q == RX_CAPT));
        capt_end = capt && beat.eof;
        len      = (&idx) ? idx : idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            idx_q   <= '0;
        end else if (beat.valid) begin
            if (beat.sof) begin
                idx_q <= len;
                if (beat.eof)   state_q <= RX_IDLE;
                else if (hold)  state_q <= RX_DROP;
                else            state_q <= RX_CAPT;
            end else if (state_q != RX_IDLE) begin
                idx_q <= len;
                if (beat.eof) state_q <= RX_IDLE;
            end
        end
    end
endmodule

// File: rtl/wop_hdr_grab.sv
module wop_hdr_grab
    import wop_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capt,
    input  logic             start,
    input  logic [LEN_W-1:0] idx,
    input  logic [7:0]       data,
    output hdr_t             hdr_next
);
    hdr_t hdr_q;
    hdr_t base;

    always_comb begin
        base     = start ? '0 : hdr_q;
        hdr_next = base;
        if (capt) begin
            for (int k = 0; k < DST_BYTES; k++) begin
                if (idx == LEN_W'(k))
                    hdr_next.dst[ADDR_W-1-8*k -: 8] = data;
            end
            if (idx == LEN_W'(ETYPE_HI_AT)) hdr_next.etype[15:8] = data;
            if (idx == LEN_W'(ETYPE_LO_AT)) hdr_next.etype[7:0]  = data;
            if (idx == LEN_W'(TIP_LO_AT))   hdr_next.tip_lo      = data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       hdr_q <= '0;
        else if (capt) hdr_q <= hdr_next;
    end
endmodule

// File: rtl/wop_match.sv
module wop_match
    import wop_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  hdr_t             hdr,
    input  logic [LEN_W-1:0] len,
    input  filt_cfg_t        cfg,
    output logic             hit
);
    logic bcast, addr_ok, type_eq, tip_eq;
    logic has_uni, has_type, has_arp;

    always_comb begin
        bcast    = is_bcast(hdr.dst);
        addr_ok  = ((hdr.dst ^ cfg.addr) & cfg.mask) == '0;
        type_eq  = hdr.etype == cfg.etype;
        tip_eq   = hdr.tip_lo == cfg.ip_lo;
        has_uni  = len >= LEN_W'(MIN_UNI);
        has_type = len >= LEN_W'(MIN_TYPED);
        has_arp  = len >= LEN_W'(MIN_ARP);
        if (!has_uni)      hit = 1'b0;
        else if (!bcast)   hit = addr_ok;
        else if (!has_type) hit = 1'b0;
        else if (type_eq)  hit = has_arp && tip_eq;
        else               hit = cfg.bcast_en;
    end
endmodule

// File: rtl/wop_frame_buf.sv
module wop_frame_buf #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/wop_arp_filter.sv
module wop_arp_filter
    import wop_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int LEN_W     = 16,
    localparam int AW       = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic [47:0]      cfg_addr,
    input  logic [47:0]      cfg_mask,
    input  logic [15:0]      cfg_etype,
    input  logic [7:0]       cfg_ip_lo,
    input  logic             cfg_bcast_en,
    input  logic             buf_clear,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data,
    output logic             buf_valid,
    output logic [LEN_W-1:0] held_len,
    output logic             wake
);
    beat_t            beat;
    filt_cfg_t        cfg;
    hdr_t             hdr_next;
    logic             capt, capt_end, start, hit, store_we;
    logic [LEN_W-1:0] idx, len;

    assign beat     = '{valid: rx_valid, sof: rx_sof, eof: rx_eof, data: rx_data};
    assign cfg      = '{addr: cfg_addr, mask: cfg_mask, etype: cfg_etype,
                        ip_lo: cfg_ip_lo, bcast_en: cfg_bcast_en};
    assign store_we = capt && (idx < LEN_W'(BUF_BYTES));

    wop_rx_track #(.LEN_W(LEN_W)) u_track (
        .clk(clk), .rst(rst), .beat(beat), .hold(buf_valid),
        .capt(capt), .capt_end(capt_end), .start(start), .idx(idx), .len(len)
    );

    wop_hdr_grab #(.LEN_W(LEN_W)) u_hdr (
        .clk(clk), .rst(rst), .capt(capt), .start(start), .idx(idx),
        .data(rx_data), .hdr_next(hdr_next)
    );

    wop_match #(.LEN_W(LEN_W)) u_match (
        .hdr(hdr_next), .len(len), .cfg(cfg), .hit(hit)
    );

    wop_frame_buf #(.DEPTH(BUF_BYTES)) u_store (
        .clk(clk), .we(store_we), .waddr(idx[AW-1:0]), .wdata(rx_data),
        .raddr(rd_addr), .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_valid <= 1'b0;
            wake      <= 1'b0;
            held_len  <= '0;
        end else begin
            wake <= 1'b0;
            if (buf_clear) buf_valid <= 1'b0;
            if (capt_end && hit) begin
                buf_valid <= 1'b1;
                wake      <= 1'b1;
                held_len  <= len;
            end
        end
    end
endmodule

// File: rtl/wop_arp_filter_chk.sv
module wop_arp_filter_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             rx_eof,
    input logic             buf_clear,
    input logic             buf_valid,
    input logic [LEN_W-1:0] held_len,
    input logic             wake
);
    p_wake_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);
    p_wake_rises_valid_r9: assert property (@(posedge clk) disable iff (rst)
        wake |-> (buf_valid && !$past(buf_valid)));
    p_wake_after_eof_r9: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(rx_valid && rx_eof));
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (buf_valid && !buf_clear) |=> (buf_valid && $stable(held_len)));
    p_clear_drops_r8: assert property (@(posedge clk) disable iff (rst)
        buf_clear |=> !buf_valid);
    p_min_len_r6: assert property (@(posedge clk) disable iff (rst)
        wake |-> (held_len >= LEN_W'(6)));
    p_valid_only_by_wake_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_valid) |-> wake);
endmodule

bind wop_arp_filter wop_arp_filter_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof),
    .buf_clear(buf_clear), .buf_valid(buf_valid), .held_len(held_len), .wake(wake)
);

// File: tb/wop_arp_filter_tb.sv
`timescale 1ns/1ps
module wop_arp_filter_tb_top;
    localparam int BUF_BYTES = 64;
    localparam int LEN_W     = 16;
    localparam int AW        = $clog2(BUF_BYTES);
    localparam logic [47:0] STA  = 48'h0200_1122_3344;
    localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;

    typedef struct packed {
        logic [47:0] dst;
        logic [15:0] typ;
        logic [7:0]  ip;
        logic [7:0]  len;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{48'h0200_1122_3344, 16'h0800, 8'h00, 8'd60,  1'b1, 4'd3},  // R3 exact
        '{48'h0200_1122_33AA, 16'h0800, 8'h00, 8'd60,  1'b1, 4'd3},  // R3 masked byte
        '{48'h0200_1122_3444, 16'h0800, 8'h00, 8'd60,  1'b0, 4'd3},  // R3 compared bit
        '{48'hFFFF_FFFF_FFFF, 16'h0806, 8'h37, 8'd60,  1'b1, 4'd4},  // R4 target ours
        '{48'hFFFF_FFFF_FFFF, 16'h0806, 8'h38, 8'd60,  1'b0, 4'd4},  // R4 target other
        '{48'hFFFF_FFFF_FFFF, 16'h0806, 8'h37, 8'd42,  1'b1, 4'd6},  // R6 ends on byte 41
        '{48'hFFFF_FFFF_FFFF, 16'h0806, 8'h37, 8'd41,  1'b0, 4'd6},  // R6 byte 41 missing
        '{48'hFFFF_FFFF_FFFF, 16'h0800, 8'h00, 8'd60,  1'b0, 4'd5},  // R5 enable off
        '{48'h0200_1122_3344, 16'h0800, 8'h00, 8'd5,   1'b0, 4'd6},  // R6 short dst
        '{48'h0200_1122_3344, 16'h0800, 8'h00, 8'd6,   1'b1, 4'd6},  // R6 dst just complete
        '{48'h0200_1122_3344, 16'h0800, 8'h00, 8'd100, 1'b1, 4'd2}   // R2 longer than store
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]       rx_data = '0;
    logic [47:0]      cfg_addr = STA, cfg_mask = 48'hFFFF_FFFF_FF00;
    logic [15:0]      cfg_etype = 16'h0806;
    logic [7:0]       cfg_ip_lo = 8'h37;
    logic             cfg_bcast_en = 1'b0, buf_clear = 1'b0;
    logic [AW-1:0]    rd_addr = '0;
    logic [7:0]       rd_data;
    logic             buf_valid, wake;
    logic [LEN_W-1:0] held_len;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wop_arp_filter #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_data(rx_data), .cfg_addr(cfg_addr), .cfg_mask(cfg_mask),
        .cfg_etype(cfg_etype), .cfg_ip_lo(cfg_ip_lo), .cfg_bcast_en(cfg_bcast_en),
        .buf_clear(buf_clear), .rd_addr(rd_addr), .rd_data(rd_data),
        .buf_valid(buf_valid), .held_len(held_len), .wake(wake)
    );

    function automatic logic [7:0] fbyte(logic [47:0] d, logic [15:0] t,
                                         logic [7:0] ip, int i);
        if (i < 6)        return d[47-8*i -: 8];
        else if (i < 12)  return 8'(8'hA0 + i);
        else if (i == 12) return t[15:8];
        else if (i == 13) return t[7:0];
        else if (i == 41) return ip;
        else              return 8'(i) ^ 8'h5A;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(logic [47:0] d, logic [15:0] t, logic [7:0] ip,
                        int n, bit with_eof);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = with_eof && (i == n - 1);
            rx_data  = fbyte(d, t, ip, i);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic release_buf();
        buf_clear = 1'b1;
        @(negedge clk);
        buf_clear = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(wake == 1'b0,      "R1", "wake after reset",      wake, 0);
        check(buf_valid == 1'b0, "R1", "buf_valid after reset", buf_valid, 0);
        check(held_len == '0,    "R1", "held_len after reset",  held_len, 0);

        for (int v = 0; v < NV; v++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[v].req);
            send(VECS[v].dst, VECS[v].typ, VECS[v].ip, int'(VECS[v].len), 1'b1);
            check(wake == VECS[v].exp, rq, $sformatf("wake vec %0d", v), wake, VECS[v].exp);
            check(buf_valid == VECS[v].exp, rq, $sformatf("buf_valid vec %0d", v),
                  buf_valid, VECS[v].exp);
            if (VECS[v].exp) begin
                check(held_len == LEN_W'(VECS[v].len), "R2", $sformatf("held_len vec %0d", v),
                      held_len, VECS[v].len);
                @(negedge clk);
                check(wake == 1'b0 && buf_valid, "R9", $sformatf("pulse ends vec %0d", v),
                      {wake, buf_valid}, 2'b01);
                release_buf();
            end else begin
                @(negedge clk);
                check(buf_valid == 1'b0, "R10", $sformatf("slot free vec %0d", v), buf_valid, 0);
            end
        end

        // R2: store contents of a frame longer than the store
        send(STA, 16'h1234, 8'h00, 100, 1'b1);
        for (int a = 0; a < BUF_BYTES; a += 21) begin
            rd_addr = AW'(a);
            #1;
            check(rd_data == fbyte(STA, 16'h1234, 8'h00, a), "R2",
                  $sformatf("store byte %0d", a), rd_data, fbyte(STA, 16'h1234, 8'h00, a));
        end
        rd_addr = AW'(BUF_BYTES - 1);
        #1;
        check(rd_data == fbyte(STA, 16'h1234, 8'h00, BUF_BYTES - 1), "R2", "last store byte",
              rd_data, fbyte(STA, 16'h1234, 8'h00, BUF_BYTES - 1));
        check(held_len == LEN_W'(100), "R2", "held_len long frame", held_len, 100);

        // R7: further frames dropped while held
        @(negedge clk);
        send(STA, 16'hBEEF, 8'h00, 50, 1'b1);
        check(wake == 1'b0, "R7", "no wake while held", wake, 0);
        check(held_len == LEN_W'(100), "R7", "held_len kept", held_len, 100);
        rd_addr = AW'(12);
        #1;
        check(rd_data == 8'h12, "R7", "stored type byte kept", rd_data, 8'h12);

        // R8: release, then next frame captured
        release_buf();
        check(buf_valid == 1'b0, "R8", "buf_valid after clear", buf_valid, 0);
        send(STA, 16'h0800, 8'h00, 30, 1'b1);
        check(wake == 1'b1, "R8", "wake after clear", wake, 1);
        release_buf();

        // R5: non-ARP broadcast with enable on
        cfg_bcast_en = 1'b1;
        send(BC, 16'h0800, 8'h00, 20, 1'b1);
        check(wake == 1'b1, "R5", "broadcast with enable", wake, 1);
        release_buf();
        // R6: broadcast too short for type, enable on
        send(BC, 16'h0800, 8'h00, 13, 1'b1);
        check(wake == 1'b0, "R6", "broadcast without type", wake, 0);
        cfg_bcast_en = 1'b0;
        @(negedge clk);

        // R11: unterminated broadcast, then a new ARP frame with a start marker
        send(BC, 16'h0806, 8'h99, 45, 1'b0);
        send(BC, 16'h0806, 8'h37, 48, 1'b1);
        check(wake == 1'b1, "R11", "restart on start marker", wake, 1);
        check(held_len == LEN_W'(48), "R11", "held_len restart", held_len, 48);
        release_buf();
        // R11: unterminated unicast hit, then a missing unicast frame
        send(STA, 16'h0800, 8'h00, 20, 1'b0);
        send(48'h0300_0000_0000, 16'h0800, 8'h00, 20, 1'b1);
        check(wake == 1'b0, "R11", "old header not reused", wake, 0);

        // R1: reset mid-hold
        send(STA, 16'h0800, 8'h00, 20, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(buf_valid == 1'b0 && held_len == '0, "R1", "reset clears hold",
              {buf_valid, held_len}, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule